// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel Sequencer

This block sequences one channel of a DMA engine that copies data from a source chain of buffers into a destination chain. Each chain is a circular ring of 64-bit descriptors in memory. Every descriptor gives a buffer address and the address of that buffer's status word. A status word holds one meaningful bit in its least significant position: 1 means full and 0 means empty.

For each step the sequencer does the following in order:
- It reads the current source descriptor, then the current destination descriptor.
- It reads the source status, then the destination status.
- If the source is full and the destination is empty, it hands the two buffer addresses and the configured length to a separate copy engine. Otherwise it waits a programmable delay and reads both statuses again.
- When the copy completes, it marks the source empty and the destination full.
- It advances both ring indices, each wrapping at its own ring length.

Any bus or copy error stops the channel and leaves a code naming the failing access on its status output.

Software loads the ring bases, ring lengths, buffer length and poll delay while the channel is idle. It then pulses start. A stop pulse brings the channel back to idle at a safe point, and it is also the only way out of an error.

Top module: `chain_dma_seq`

## Requirements
- R1: After reset `chan_status` is 0, `mem_req` is low and `cp_start` is low.
- R2: At ring index i the source descriptor is read as one 64-bit access at address `src_base + 8*i`, then the destination descriptor at `dst_base + 8*j`. Bits [5:0] of a written base are forced to zero.
- R3: A descriptor d decodes to buffer address `{d[63:52], d[51:26], 6'b0}` and status address `{d[63:52], d[25:0], 6'b0}`. After both descriptors, the source status is read, then the destination status.
- R4: `cp_start` pulses for one cycle only when the source status bit 0 read 1 and the destination status bit 0 read 0. `cp_src`, `cp_dst` and `cp_len` then carry the two decoded buffer addresses and the configured buffer length.
- R5: If the copy condition fails, no access is issued for at least `poll delay + 1` cycles. The source status, then the destination status, is then read again, without re-reading descriptors.
- R6: After `cp_done` without `cp_err`, 64'h0 is written to the source status and then 64'h1 to the destination status. Both indices then advance by one, each wrapping to 0 when it reaches its ring length, and the next step begins.
- R7: While running, `chan_status` is above 5. Error codes are 1 for a source descriptor error, 2 for a destination descriptor error, 3 for a source status error (read or write), 4 for a destination status error (read or write) and 5 for a copy error.
- R8: In an error state the channel issues no access and ignores start. A stop returns it to 0, and a later start begins again at index 0 of both rings.
- R9: Configuration writes (`cfg_sel` 0 source base, 1 destination base, 2 source ring length, 3 destination ring length, 4 buffer length, 5 poll delay) take effect only while `chan_status` is 0.
- R10: A stop while running takes effect during a poll wait or at the end of the current step. An access or copy already under way is always finished first, and the channel then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 44 | Configuration write data |
| ctl_start | input | 1 | Start pulse |
| ctl_stop | input | 1 | Stop pulse |
| chan_status | output | 4 | Idle, error or running code |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 44 | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | One-cycle request completion |
| mem_err | input | 1 | Bus error with the acknowledge |
| mem_rdata | input | 64 | Read data with the acknowledge |
| cp_start | output | 1 | One-cycle copy launch |
| cp_src | output | 44 | Source buffer address |
| cp_dst | output | 44 | Destination buffer address |
| cp_len | output | 16 | Bytes to copy |
| cp_done | input | 1 | Copy finished pulse |
| cp_err | input | 1 | Copy failed, valid with `cp_done` |

## Verification
The main loop runs first with a full source ring and an empty destination ring, so that two clean steps show the exact access order, the descriptor decoding and the status writeback. The source ring is two entries long and the destination ring three. The third step wraps only the source index, and the fourth wraps only the destination, which separates the two modulo counters. A buffer whose status was cleared by an earlier step then forces polling; the poll gap, the absence of any new copy and the resumed copy once the bench sets the status to full separate the wait path from the copy path. Faults are injected at each of the five failing points in turn, each of which must yield its own code, block further traffic and ignore start until stop.

// File: rtl/chain_dma_seq.sv
module chain_dma_seq #(
  parameter int LEN_W = 8,
  parameter int BL_W  = 16,
  parameter int DLY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [43:0]       cfg_wdata,
  input  logic              ctl_start,
  input  logic              ctl_stop,
  output logic [3:0]        chan_status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [43:0]       mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [63:0]       mem_rdata,
  output logic              cp_start,
  output logic [43:0]       cp_src,
  output logic [43:0]       cp_dst,
  output logic [BL_W-1:0]   cp_len,
  input  logic              cp_done,
  input  logic              cp_err
);
  localparam int AW  = 44;
  localparam int PAD = AW - LEN_W - 3;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_E_SD = 4'd1, S_E_DD = 4'd2, S_E_SS = 4'd3, S_E_DS = 4'd4,
    S_E_CP = 4'd5, S_RSD = 4'd6, S_RDD = 4'd7, S_RSS = 4'd8, S_RDS = 4'd9,
    S_WAIT = 4'd10, S_GO = 4'd11, S_COPY = 4'd12, S_WSS = 4'd13, S_WDS = 4'd14
  } st_t;

  st_t              st;
  logic [AW-1:0]    sbase, dbase;
  logic [LEN_W-1:0] slen, dlen, sidx, didx, sidx_nx, didx_nx;
  logic [BL_W-1:0]  blen;
  logic [DLY_W-1:0] dly, wcnt;
  logic [63:0]      sdesc, ddesc;
  logic             sfull, stop_pend;
  logic [LEN_W:0]   s_inc, d_inc;
  logic             cfg_unused;

  assign cfg_unused = ^cfg_wdata;

  function automatic logic [AW-1:0] buf_of(input logic [63:0] d);
    return {d[63:52], d[51:26], 6'b0};
  endfunction

  function automatic logic [AW-1:0] stat_of(input logic [63:0] d);
    return {d[63:52], d[25:0], 6'b0};
  endfunction

  assign s_inc   = {1'b0, sidx} + 1'b1;
  assign d_inc   = {1'b0, didx} + 1'b1;
  assign sidx_nx = (s_inc >= {1'b0, slen}) ? '0 : s_inc[LEN_W-1:0];
  assign didx_nx = (d_inc >= {1'b0, dlen}) ? '0 : d_inc[LEN_W-1:0];

  assign chan_status = st;
  assign mem_req   = (st == S_RSD) || (st == S_RDD) || (st == S_RSS) ||
                     (st == S_RDS) || (st == S_WSS) || (st == S_WDS);
  assign mem_we    = (st == S_WSS) || (st == S_WDS);
  assign mem_wdata = (st == S_WDS) ? 64'd1 : 64'd0;
  assign cp_start  = (st == S_GO);
  assign cp_src    = buf_of(sdesc);
  assign cp_dst    = buf_of(ddesc);
  assign cp_len    = blen;

  always_comb begin
    case (st)
      S_RSD:        mem_addr = sbase + {{PAD{1'b0}}, sidx, 3'b000};
      S_RDD:        mem_addr = dbase + {{PAD{1'b0}}, didx, 3'b000};
      S_RSS, S_WSS: mem_addr = stat_of(sdesc);
      S_RDS, S_WDS: mem_addr = stat_of(ddesc);
      default:      mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbase <= '0; dbase <= '0; slen <= '0; dlen <= '0;
      blen  <= '0; dly   <= '0;
    end else if (cfg_we && st == S_IDLE) begin
      case (cfg_sel)
        3'd0: sbase <= {cfg_wdata[AW-1:6], 6'b0};
        3'd1: dbase <= {cfg_wdata[AW-1:6], 6'b0};
        3'd2: slen  <= cfg_wdata[LEN_W-1:0];
        3'd3: dlen  <= cfg_wdata[LEN_W-1:0];
        3'd4: blen  <= cfg_wdata[BL_W-1:0];
        3'd5: dly   <= cfg_wdata[DLY_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sidx <= '0; didx <= '0; wcnt <= '0;
      sdesc <= '0; ddesc <= '0; sfull <= 1'b0; stop_pend <= 1'b0;
    end else begin
      if (st >= S_RSD && ctl_stop) stop_pend <= 1'b1;
      case (st)
        S_IDLE: if (ctl_start && !ctl_stop) begin
          sidx <= '0; didx <= '0; stop_pend <= 1'b0; st <= S_RSD;
        end
        S_E_SD, S_E_DD, S_E_SS, S_E_DS, S_E_CP:
          if (ctl_stop) st <= S_IDLE;
        S_RSD: if (mem_ack) begin
          if (mem_err) st <= S_E_SD;
          else begin sdesc <= mem_rdata; st <= S_RDD; end
        end
        S_RDD: if (mem_ack) begin
          if (mem_err) st <= S_E_DD;
          else begin ddesc <= mem_rdata; st <= S_RSS; end
        end
        S_RSS: if (mem_ack) begin
          if (mem_err) st <= S_E_SS;
          else begin sfull <= mem_rdata[0]; st <= S_RDS; end
        end
        S_RDS: if (mem_ack) begin
          if (mem_err) st <= S_E_DS;
          else if (sfull && !mem_rdata[0]) st <= S_GO;
          else if (stop_pend || ctl_stop) st <= S_IDLE;
          else begin wcnt <= dly; st <= S_WAIT; end
        end
        S_WAIT: begin
          if (stop_pend || ctl_stop) st <= S_IDLE;
          else if (wcnt == '0) st <= S_RSS;
          else wcnt <= wcnt - 1'b1;
        end
        S_GO: st <= S_COPY;
        S_COPY: if (cp_done) st <= cp_err ? S_E_CP : S_WSS;
        S_WSS: if (mem_ack) st <= mem_err ? S_E_SS : S_WDS;
        S_WDS: if (mem_ack) begin
          if (mem_err) st <= S_E_DS;
          else begin
            sidx <= sidx_nx;
            didx <= didx_nx;
            st   <= (stop_pend || ctl_stop) ? S_IDLE : S_RSD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_status == 4'd0) |-> (!mem_req && !cp_start));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_go_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cp_start |=> !cp_start);

  p_idx_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && slen != '0 && dlen != '0) |-> (sidx < slen && didx < dlen));

  p_run_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || cp_start) |-> (chan_status > 4'd5));

  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_status >= 4'd1 && chan_status <= 4'd5 && !ctl_stop)
      |=> ($stable(chan_status) && !mem_req && !cp_start));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable({sbase, dbase, slen, dlen, blen, dly}));
endmodule

// File: tb/sim_chain_dma_seq.sv
module sim_chain_dma_seq;
  localparam int CLK_P = 10;
  localparam int LAT   = 2;
  localparam int POLL  = 5;
  localparam int BLEN  = 256;
  localparam int LIMIT = 100000;
  localparam logic [43:0] SB_RAW = 44'h000_1000_007F;
  localparam logic [43:0] SBA    = 44'h000_1000_0040;
  localparam logic [43:0] DBA    = 44'h000_2000_0100;
  localparam logic [43:0] SB_ALT = 44'h000_3000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [2:0] cfg_sel = '0; logic [43:0] cfg_wdata = '0;
  logic ctl_start = 1'b0, ctl_stop = 1'b0;
  logic [3:0] chan_status;
  logic mem_req, mem_we; logic [43:0] mem_addr; logic [63:0] mem_wdata;
  logic mem_ack = 1'b0, mem_err = 1'b0; logic [63:0] mem_rdata = '0;
  logic cp_start; logic [43:0] cp_src, cp_dst; logic [15:0] cp_len;
  logic cp_done = 1'b0, cp_err = 1'b0;

  chain_dma_seq u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [63:0] mem [logic [43:0]];
  logic [43:0] err_addr = '0; bit err_on = 0; bit copy_fail = 0;
  int mcnt = 0, cp_cnt = 0;
  int log_n = 0, cp_seen = 0;
  logic [43:0] log_addr [64]; logic log_we [64]; logic [63:0] log_wd [64]; int log_cyc [64];
  logic [43:0] cps_log [8]; logic [43:0] cpd_log [8]; logic [15:0] cpl_log [8];

  function automatic logic [63:0] sd(int i);
    return {12'h3C5, 26'h100 + 26'(i), 26'h200 + 26'(i)};
  endfunction
  function automatic logic [43:0] sbuf(int i); return {12'h3C5, 26'h100 + 26'(i), 6'b0}; endfunction
  function automatic logic [43:0] sst(int i);  return {12'h3C5, 26'h200 + 26'(i), 6'b0}; endfunction
  function automatic logic [63:0] dd(int i);
    return {12'h7E1, 26'h300 + 26'(i), 26'h400 + 26'(i)};
  endfunction
  function automatic logic [43:0] dbuf(int i); return {12'h7E1, 26'h300 + 26'(i), 6'b0}; endfunction
  function automatic logic [43:0] dst(int i);  return {12'h7E1, 26'h400 + 26'(i), 6'b0}; endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog expired at cycle %0d (expected completion)", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin mem_ack = 0; mem_err = 0; mcnt = 0; end
    else if (mem_ack) begin mem_ack = 0; mem_err = 0; mcnt = 0; end
    else if (mem_req) begin
      mcnt++;
      if (mcnt >= LAT) begin
        mcnt = 0; mem_ack = 1;
        mem_err = err_on && (mem_addr == err_addr);
        if (mem_we && !mem_err) mem[mem_addr] = mem_wdata;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
        if (log_n < 64) begin
          log_addr[log_n] = mem_addr; log_we[log_n] = mem_we;
          log_wd[log_n] = mem_wdata; log_cyc[log_n] = cyc;
        end
        log_n++;
      end
    end else mcnt = 0;
  end

  always @(negedge clk) begin
    if (cp_done) begin cp_done = 0; cp_err = 0; end
    else if (cp_start) begin
      if (cp_seen < 8) begin
        cps_log[cp_seen] = cp_src; cpd_log[cp_seen] = cp_dst; cpl_log[cp_seen] = cp_len;
      end
      cp_seen++; cp_cnt = 3;
    end else if (cp_cnt > 0) begin
      cp_cnt--;
      if (cp_cnt == 0) begin cp_done = 1; cp_err = copy_fail; end
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_acc(int k, logic [43:0] a, logic w, logic [63:0] wd, string req);
    if (k >= log_n) chk(0, {req, " access missing"}, 64'(log_n), 64'(k + 1));
    else begin
      chk(log_addr[k] == a, {req, " addr"}, 64'(log_addr[k]), 64'(a));
      chk(log_we[k] == w, {req, " dir"}, 64'(log_we[k]), 64'(w));
      if (w) chk(log_wd[k] == wd, {req, " wdata"}, log_wd[k], wd);
    end
  endtask

  task automatic cfg(int sel, logic [43:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); ctl_start = 1; @(negedge clk); ctl_start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); ctl_stop = 1; @(negedge clk); ctl_stop = 0;
  endtask

  task automatic wait_log(int n);
    for (int i = 0; i < 3000 && log_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_cp(int n);
    for (int i = 0; i < 3000 && cp_seen < n; i++) @(negedge clk);
  endtask

  task automatic wait_status(logic [3:0] c);
    for (int i = 0; i < 3000 && chan_status != c; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(chan_status == 0, "R1 status", 64'(chan_status), 0);
    chk(!mem_req, "R1 mem_req", 64'(mem_req), 0);
    chk(!cp_start, "R1 cp_start", 64'(cp_start), 0);
  endtask

  task automatic t_steps();
    int b;
    for (int i = 0; i < 4; i++) begin mem[SBA + 44'(8*i)] = sd(i); mem[DBA + 44'(8*i)] = dd(i); end
    mem[sst(0)] = 1; mem[sst(1)] = 1;
    mem[dst(0)] = 0; mem[dst(1)] = 0; mem[dst(2)] = 0;
    cfg(0, SB_RAW); cfg(1, DBA); cfg(2, 2); cfg(3, 3); cfg(4, BLEN); cfg(5, POLL);
    log_n = 0; cp_seen = 0;
    pulse_start();
    chk(chan_status > 5, "R7 running code", 64'(chan_status), 6);
    wait_log(12);
    for (int s = 0; s < 2; s++) begin
      chk_acc(6*s + 0, SBA + 44'(8*s), 0, 0, "R2 src desc");
      chk_acc(6*s + 1, DBA + 44'(8*s), 0, 0, "R2 dst desc");
      chk_acc(6*s + 2, sst(s), 0, 0, "R3 src status");
      chk_acc(6*s + 3, dst(s), 0, 0, "R3 dst status");
      chk_acc(6*s + 4, sst(s), 1, 64'h0, "R6 src status clear");
      chk_acc(6*s + 5, dst(s), 1, 64'h1, "R6 dst status set");
      chk(cps_log[s] == sbuf(s), "R4 cp_src", 64'(cps_log[s]), 64'(sbuf(s)));
      chk(cpd_log[s] == dbuf(s), "R4 cp_dst", 64'(cpd_log[s]), 64'(dbuf(s)));
      chk(cpl_log[s] == 16'(BLEN), "R4 cp_len", 64'(cpl_log[s]), 64'(BLEN));
    end
    wait_log(17);
    chk_acc(12, SBA, 0, 0, "R6 src wrap");
    chk_acc(13, DBA + 44'd16, 0, 0, "R6 dst index 2");
    chk_acc(14, sst(0), 0, 0, "R5 poll src");
    chk_acc(15, dst(2), 0, 0, "R5 poll dst");
    chk_acc(16, sst(0), 0, 0, "R5 repoll src status");
    chk(log_cyc[16] - log_cyc[15] > POLL, "R5 poll gap", 64'(log_cyc[16] - log_cyc[15]), 64'(POLL + 1));
    chk(cp_seen == 2, "R4 no copy while empty", 64'(cp_seen), 2);
    cfg(0, SB_ALT);
    mem[sst(0)] = 1;
    wait_cp(3);
    b = log_n;
    chk(cps_log[2] == sbuf(0), "R4 cp_src after poll", 64'(cps_log[2]), 64'(sbuf(0)));
    chk(cpd_log[2] == dbuf(2), "R4 cp_dst after poll", 64'(cpd_log[2]), 64'(dbuf(2)));
    wait_log(b + 6);
    chk_acc(b + 0, sst(0), 1, 64'h0, "R6 clear after poll");
    chk_acc(b + 1, dst(2), 1, 64'h1, "R6 set after poll");
    chk_acc(b + 2, SBA + 44'd8, 0, 0, "R6 src index 1");
    chk_acc(b + 3, DBA, 0, 0, "R6 dst wrap");
    wait_status(4'd10);
    chk(chan_status == 10, "R5 waiting", 64'(chan_status), 10);
    pulse_stop();
    chk(chan_status == 0, "R10 stop in wait", 64'(chan_status), 0);
  endtask

  task automatic t_restart_stop();
    log_n = 0;
    pulse_start();
    wait_log(2);
    chk_acc(0, SBA, 0, 0, "R9 base write ignored while running");
    pulse_stop();
    chk(chan_status > 5, "R10 stop deferred", 64'(chan_status), 6);
    wait_status(4'd0);
    chk(chan_status == 0, "R10 idle after step", 64'(chan_status), 0);
    chk(log_n >= 4, "R10 step finished", 64'(log_n), 4);
  endtask

  task automatic t_err(logic [3:0] code, logic [43:0] ea, bit use_ea, string req);
    int n0;
    err_on = use_ea; err_addr = ea; copy_fail = !use_ea;
    pulse_start();
    wait_status(code);
    chk(chan_status == code, {req, " error code"}, 64'(chan_status), 64'(code));
    n0 = log_n;
    repeat (20) @(negedge clk);
    chk(log_n == n0 && !mem_req, "R8 no access in error", 64'(log_n), 64'(n0));
    pulse_start();
    chk(chan_status == code, "R8 start ignored", 64'(chan_status), 64'(code));
    pulse_stop();
    chk(chan_status == 0, "R8 stop clears", 64'(chan_status), 0);
    err_on = 0; copy_fail = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_steps();
    t_restart_stop();
    t_err(4'd1, SBA, 1, "R7 src desc");
    t_err(4'd2, DBA, 1, "R7 dst desc");
    t_err(4'd3, sst(0), 1, "R7 src status");
    t_err(4'd4, dst(0), 1, "R7 dst status");
    mem[sst(0)] = 1; mem[dst(0)] = 0;
    t_err(4'd5, '0, 0, "R7 copy");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule